// File: doc/BRIEF.md
# I2S Stereo Audio Serial Port

This block sits between an audio codec's serial pins and on-chip sample processing. From the master audio clock it derives the serial bit clock and the word-select clock. Both receive and transmit share these two clocks. On the receive side it turns the incoming serial data line into 24-bit left/right sample pairs. On the transmit side it turns sample pairs back into a serial data line. Samples are signed fixed-point values with one sign bit and 23 fraction bits.

Framing follows standard I2S. Word-select low marks the left channel and high marks the right. Each channel occupies a slot of `SLOT_W` bit clocks. The most significant bit of a sample sits in the first bit clock after the word-select change. Only the first `SAMPLE_W` bits of a slot carry data. The receiver samples data on bit-clock rising edges and the transmitter changes data on bit-clock falling edges.

Received pairs leave on a valid/ready stream. `rx_valid` stays high and the pair stays stable until the consumer raises `rx_ready`. Back-pressure is not propagated to the serial line, because the codec cannot be stalled. If a further pair completes while one is still waiting, the new pair replaces it and a sticky overflow flag is set. Transmit pairs enter through a single holding slot. `tx_ready` is high while that slot is empty, and a pair is taken on a cycle with `tx_valid` and `tx_ready` both high. The held pair is sent at the next frame start. If the slot is empty at that point, the frame carries zeros.

Top module: `i2s_stereo_mac`

## Requirements
- R1: `bclk` is low after reset and then has a period of `BCLK_DIV` master clocks, high for `BCLK_DIV/2` of them.
- R2: `lrck` is low (left) after reset and toggles every `SLOT_W` bit-clock periods. It changes only on the master clock edge where `bclk` goes from 0 to 1.
- R3: The receiver samples `sd_in` on each `bclk` rising edge. The rising edge that immediately follows a word-select change is slot bit 0, the MSB. Slot bits 0 to `SAMPLE_W-1` form the sample, and bits `SAMPLE_W` to `SLOT_W-1` are ignored whatever their value.
- R4: `rx_valid` rises after the last data bit of the right slot, with the pair of that frame on `rx_left`/`rx_right`. While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and the pair is stable (unless an overflow replaces it). After a cycle with both high, `rx_valid` drops unless a new pair completes.
- R5: A pair that completes while `rx_valid` is high and `rx_ready` is low replaces the waiting pair and sets `rx_overflow`. The flag then stays high until reset.
- R6: `tx_ready` is high while the transmit holding slot is empty. The pair is taken on a cycle with `tx_valid` and `tx_ready` high, and `tx_ready` is low from the next cycle until the pair moves to the serializer at frame start. `tx_valid` while `tx_ready` is low has no effect.
- R7: `sd_out` changes only on the master edge where `bclk` falls. A taken pair is sent in the next frame (left slot first), MSB first, with the slot's bits `SAMPLE_W` to `SLOT_W-1` driven 0. Looping `sd_out` into `sd_in` returns the same pair on the receive stream.
- R8: A frame that starts with the holding slot empty sends 0 in both channels.
- R9: While `rst_n` is low: `bclk`, `lrck`, `sd_out`, `rx_valid` and `rx_overflow` are 0, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_in | input | 1 | Serial receive data from the codec |
| rx_ready | input | 1 | Consumer accepts the receive pair |
| tx_valid | input | 1 | Transmit pair offered |
| tx_left | input | SAMPLE_W | Transmit left sample |
| tx_right | input | SAMPLE_W | Transmit right sample |
| bclk | output | 1 | Serial bit clock, shared by both directions |
| lrck | output | 1 | Word-select: 0 left, 1 right |
| sd_out | output | 1 | Serial transmit data to the codec |
| rx_valid | output | 1 | Receive pair available |
| rx_left | output | SAMPLE_W | Received left sample |
| rx_right | output | SAMPLE_W | Received right sample |
| rx_overflow | output | 1 | Sticky: a receive pair was overwritten |
| tx_ready | output | 1 | Transmit holding slot empty |

## Verification
The bench builds the block with its defaults: a divider of 8, 32-bit slots and 24-bit samples. One frame is therefore 512 master clocks, so every scenario, including a double completion for overflow, fits in a few thousand cycles. The eight idle bits at the end of each slot are exercised on both sides: the bench drives them as ones into the receiver and watches that the transmitter keeps them at zero. The full-scale values 0x800000 and 0x7FFFFF test that the sign bit is placed correctly in the MSB position.

// File: rtl/i2s_mac_pkg.sv
package i2s_mac_pkg;

  // Channel carried by the current slot; the value is the word-select level.
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

endpackage

// File: rtl/i2s_bitclk_gen.sv
module i2s_bitclk_gen
  import i2s_mac_pkg::*;
#(
  parameter int BCLK_DIV = 8,
  parameter int SLOT_W   = 32,
  localparam int HALF    = BCLK_DIV / 2,
  localparam int CW      = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int SW      = $clog2(SLOT_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          bclk,
  output logic          lrck,
  output logic          bit_rise,
  output logic          bit_fall,
  output chan_e         chan,
  output logic [SW-1:0] slot_idx
);

  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_W - 1);

  logic [CW-1:0] half_cnt;
  logic [SW-1:0] bit_cnt;
  logic          half_wrap;

  assign half_wrap = (half_cnt == HALF_LAST);
  // Strobes mark the master edge at which bclk changes level.
  assign bit_rise  = half_wrap & ~bclk;
  assign bit_fall  = half_wrap & bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      bclk     <= 1'b0;
    end else if (half_wrap) begin
      half_cnt <= '0;
      bclk     <= ~bclk;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  // Word-select steps once per bit-clock period, on the rising strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      lrck    <= 1'b0;
    end else if (bit_rise) begin
      if (bit_cnt == SLOT_LAST) begin
        bit_cnt <= '0;
        lrck    <= ~lrck;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign chan     = lrck ? CH_RIGHT : CH_LEFT;
  assign slot_idx = bit_cnt;

  // R2
  lrck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lrck != $past(lrck)) |-> (bclk && !$past(bclk)));

endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
  import i2s_mac_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int SW      = $clog2(SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_rise,
  input  chan_e               chan,
  input  logic [SW-1:0]       slot_idx,
  input  logic                sd_in,
  input  logic                rx_ready,
  output logic                rx_valid,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_overflow
);

  localparam logic [SW-1:0] LAST_DATA = SW'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] left_sh;
  logic [SAMPLE_W-1:0] right_sh;
  logic                in_data;
  logic                pair_done;

  assign in_data   = bit_rise && (slot_idx <= LAST_DATA);
  assign pair_done = in_data && (chan == CH_RIGHT) && (slot_idx == LAST_DATA);

  // Shift only data bits; the slot tail never reaches the registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_sh  <= '0;
      right_sh <= '0;
    end else if (in_data) begin
      if (chan == CH_LEFT) left_sh  <= {left_sh[SAMPLE_W-2:0], sd_in};
      else                 right_sh <= {right_sh[SAMPLE_W-2:0], sd_in};
    end
  end

  // Output holding register with valid/ready; a newer pair wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid    <= 1'b0;
      rx_left     <= '0;
      rx_right    <= '0;
      rx_overflow <= 1'b0;
    end else begin
      if (pair_done) begin
        rx_valid <= 1'b1;
        rx_left  <= left_sh;
        rx_right <= {right_sh[SAMPLE_W-2:0], sd_in};
        if (rx_valid && !rx_ready) rx_overflow <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow);

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R4
  rx_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (($stable(rx_left) && $stable(rx_right)) || rx_overflow));

endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
  import i2s_mac_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int SW      = $clog2(SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_fall,
  input  chan_e               chan,
  input  logic [SW-1:0]       slot_idx,
  input  logic                tx_valid,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                tx_ready,
  output logic                sd_out
);

  localparam logic [SW-1:0] LAST_DATA = SW'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic                hold_v;
  logic [SAMPLE_W-1:0] cur_l, cur_r;
  logic [SAMPLE_W-1:0] src_l, src_r, word, shifted;
  logic                frame_start;
  logic                take;
  logic                next_bit;

  // On a falling strobe, slot_idx already names the bit the receiver takes next.
  assign frame_start = bit_fall && (chan == CH_LEFT) && (slot_idx == '0);
  assign take        = tx_valid && !hold_v;
  assign tx_ready    = !hold_v;

  always_comb begin
    if (frame_start) begin
      src_l = hold_v ? hold_l : '0;
      src_r = hold_v ? hold_r : '0;
    end else begin
      src_l = cur_l;
      src_r = cur_r;
    end
    word     = (chan == CH_LEFT) ? src_l : src_r;
    shifted  = word << slot_idx;
    next_bit = (slot_idx <= LAST_DATA) ? shifted[SAMPLE_W-1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
    end else if (take) begin
      hold_v <= 1'b1;
      hold_l <= tx_left;
      hold_r <= tx_right;
    end else if (frame_start) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_l  <= '0;
      cur_r  <= '0;
      sd_out <= 1'b0;
    end else if (bit_fall) begin
      cur_l  <= src_l;
      cur_r  <= src_r;
      sd_out <= next_bit;
    end
  end

  // R6
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

endmodule

// File: rtl/i2s_stereo_mac.sv
module i2s_stereo_mac
  import i2s_mac_pkg::*;
#(
  parameter int BCLK_DIV = 8,
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sd_in,
  input  logic                rx_ready,
  input  logic                tx_valid,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                bclk,
  output logic                lrck,
  output logic                sd_out,
  output logic                rx_valid,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_overflow,
  output logic                tx_ready
);

  localparam int SW = $clog2(SLOT_W);

  logic          bit_rise, bit_fall;
  chan_e         chan;
  logic [SW-1:0] slot_idx;

  i2s_bitclk_gen #(.BCLK_DIV(BCLK_DIV), .SLOT_W(SLOT_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck),
    .bit_rise(bit_rise), .bit_fall(bit_fall), .chan(chan), .slot_idx(slot_idx)
  );

  i2s_rx_deser #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .chan(chan), .slot_idx(slot_idx),
    .sd_in(sd_in), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_left(rx_left), .rx_right(rx_right), .rx_overflow(rx_overflow)
  );

  i2s_tx_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .chan(chan), .slot_idx(slot_idx),
    .tx_valid(tx_valid), .tx_left(tx_left), .tx_right(tx_right),
    .tx_ready(tx_ready), .sd_out(sd_out)
  );

  // R7
  sd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_out != $past(sd_out)) |-> (!bclk && $past(bclk)));

endmodule

// File: tb/i2s_stereo_mac_tb.sv
module i2s_stereo_mac_tb;

  localparam int DIV = 8;
  localparam int SLT = 32;
  localparam int SMP = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           sd_in, rx_ready = 1'b1, tx_valid = 1'b0;
  logic [SMP-1:0] tx_left = '0, tx_right = '0;
  logic           bclk, lrck, sd_out, rx_valid, rx_overflow, tx_ready;
  logic [SMP-1:0] rx_left, rx_right;

  int nvec = 0;
  int nbad = 0;
  int tail_err = 0;

  // Bench serializer source and routing.
  logic           use_loop = 1'b0;
  logic [SMP-1:0] src_l = '0, src_r = '0;
  logic           src_tail = 1'b0;
  logic           ser_bit = 1'b0;
  int             trk_idx = 0;
  logic           trk_lr = 1'b0;
  int             nidx;
  logic [SMP-1:0] wsel;

  assign sd_in = use_loop ? sd_out : ser_bit;

  i2s_stereo_mac #(.BCLK_DIV(DIV), .SLOT_W(SLT), .SAMPLE_W(SMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .sd_in(sd_in), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_left(tx_left), .tx_right(tx_right),
    .bclk(bclk), .lrck(lrck), .sd_out(sd_out), .rx_valid(rx_valid),
    .rx_left(rx_left), .rx_right(rx_right), .rx_overflow(rx_overflow),
    .tx_ready(tx_ready)
  );

  // Track the slot bit index of the coming rising edge, from the pins only.
  always @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      trk_idx <= 0;
      trk_lr  <= 1'b0;
      ser_bit <= 1'b0;
    end else begin
      if (lrck != trk_lr) nidx = 0;
      else                nidx = trk_idx + 1;
      trk_lr  <= lrck;
      trk_idx <= nidx;
      wsel = lrck ? src_r : src_l;
      ser_bit <= (nidx < SMP) ? wsel[SMP-1-nidx] : src_tail;
    end
  end

  // R7: slot tail bits on sd_out must be zero.
  always @(posedge bclk) begin
    if (rst_n && use_loop && trk_idx >= SMP && sd_out) tail_err++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_beat(output logic [SMP-1:0] l, output logic [SMP-1:0] r);
    int n = 0;
    do begin tick(); n++; end while (!(rx_valid && rx_ready) && n < 2000);
    if (n >= 2000) chk("R4 beat timeout", 64'(0), 64'(1));
    l = rx_left;
    r = rx_right;
  endtask

  task automatic send(input logic [SMP-1:0] l, input logic [SMP-1:0] r);
    int n = 0;
    while (!tx_ready && n < 2000) begin tick(); n++; end
    tx_left  = l;
    tx_right = r;
    tx_valid = 1'b1;
    tick();
    tx_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 bclk", 64'(bclk), 64'(0));
    chk("R9 lrck", 64'(lrck), 64'(0));
    chk("R9 sd_out", 64'(sd_out), 64'(0));
    chk("R9 rx_valid", 64'(rx_valid), 64'(0));
    chk("R9 rx_overflow", 64'(rx_overflow), 64'(0));
    chk("R9 tx_ready", 64'(tx_ready), 64'(1));
  endtask

  task automatic t_clock();
    logic pb = bclk, plr = lrck;
    int last_rise = -1, period = 0, high = 0, rises = 0, slot_len = 0, misalign = 0, slots = 0;
    for (int cyc = 0; cyc < 1200; cyc++) begin
      tick();
      if (bclk && !pb) begin
        if (last_rise >= 0) period = cyc - last_rise;
        last_rise = cyc;
        rises++;
      end
      if (!bclk && pb && last_rise >= 0) high = cyc - last_rise;
      if (lrck != plr) begin
        if (!(bclk && !pb)) misalign++;
        if (slots > 0) slot_len = rises;
        slots++;
        rises = 0;
      end
      pb = bclk;
      plr = lrck;
    end
    chk("R1 bclk period", 64'(period), 64'(DIV));
    chk("R1 bclk high", 64'(high), 64'(DIV / 2));
    chk("R2 slot length", 64'(slot_len), 64'(SLT));
    chk("R2 lrck on bclk rise", 64'(misalign), 64'(0));
  endtask

  task automatic rx_case(input logic [SMP-1:0] l, input logic [SMP-1:0] r, input logic tail);
    logic [SMP-1:0] gl, gr;
    wait_beat(gl, gr);
    src_l = l;
    src_r = r;
    src_tail = tail;
    wait_beat(gl, gr);
    chk("R3 rx left", 64'(gl), 64'(l));
    chk("R3 rx right", 64'(gr), 64'(r));
  endtask

  task automatic t_rx();
    use_loop = 1'b0;
    rx_case(24'h123456, 24'hABCDEF, 1'b1);
    rx_case(24'h800000, 24'h7FFFFF, 1'b1);
    rx_case(24'h000001, 24'hFFFFFE, 1'b0);
    // R4: valid drops after the handshake cycle
    tick();
    chk("R4 valid cleared", 64'(rx_valid), 64'(0));
  endtask

  task automatic t_loop();
    logic [SMP-1:0] gl, gr;
    logic [SMP-1:0] pl [4] = '{24'hC0FFEE, 24'h800000, 24'h7FFFFF, 24'h5A5A5A};
    logic [SMP-1:0] pr [4] = '{24'h0F0F0F, 24'h000001, 24'hFFFFFF, 24'hA5A5A5};
    use_loop = 1'b1;
    tail_err = 0;
    for (int i = 0; i < 4; i++) begin
      wait_beat(gl, gr);
      send(pl[i], pr[i]);
      wait_beat(gl, gr);
      chk("R7 loop left", 64'(gl), 64'(pl[i]));
      chk("R7 loop right", 64'(gr), 64'(pr[i]));
    end
    chk("R7 tail zero", 64'(tail_err), 64'(0));
  endtask

  task automatic t_hold_zero();
    logic [SMP-1:0] gl, gr;
    use_loop = 1'b1;
    wait_beat(gl, gr);
    send(24'h13579B, 24'h2468AC);
    chk("R6 ready low after take", 64'(tx_ready), 64'(0));
    tx_left  = 24'hDEAD01;
    tx_right = 24'hBEEF02;
    tx_valid = 1'b1;
    repeat (10) tick();
    tx_valid = 1'b0;
    wait_beat(gl, gr);
    chk("R6 held left", 64'(gl), 64'(24'h13579B));
    chk("R6 held right", 64'(gr), 64'(24'h2468AC));
    wait_beat(gl, gr);
    chk("R8 zero left", 64'(gl), 64'(0));
    chk("R8 zero right", 64'(gr), 64'(0));
  endtask

  task automatic t_overflow();
    logic [SMP-1:0] gl, gr;
    int n = 0;
    rx_ready = 1'b0;
    do begin tick(); n++; end while (!rx_valid && n < 2000);
    chk("R5 no overflow on first pair", 64'(rx_overflow), 64'(0));
    repeat (560) tick();
    chk("R5 overflow set", 64'(rx_overflow), 64'(1));
    chk("R4 valid held", 64'(rx_valid), 64'(1));
    rx_ready = 1'b1;
    wait_beat(gl, gr);
    wait_beat(gl, gr);
    chk("R5 overflow sticky", 64'(rx_overflow), 64'(1));
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R9 overflow cleared", 64'(rx_overflow), 64'(0));
    chk("R9 tx_ready after reset", 64'(tx_ready), 64'(1));
    rst_n = 1'b1;
  endtask

  logic done = 1'b0;

  initial begin
    repeat (4) tick();
    t_reset();
    rst_n = 1'b1;
    t_clock();
    t_rx();
    t_loop();
    t_hold_zero();
    t_overflow();
    repeat (10) tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      chk("watchdog expired", 64'(0), 64'(1));
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule